// File: doc/BRIEF.md
# LED Open-String Fault Capture

This block gathers the results of sixteen per-channel open-string comparators into a status holding word. A channel's comparator reports 1 when its output pin sits below the detection threshold, which points to either an open LED string or a pin shorted to ground. When the holding word is refreshed, the block raises a one-cycle strobe. The readout shift register uses that strobe to parallel-load the word.

A capture can be triggered in one of two ways. In normal operation it fires on a rising edge of the blanking input, but only when the 2-bit capture-select field holds the fault-status code. In detection mode a working-time counter sets the moment of capture. A 2-bit field chooses one of four cycle counts for that counter, and the blanking edge is ignored while detection mode is on.

Before a comparator bit is stored, it passes through three qualifiers:
- Channels whose enable bit is clear are stored as 0, except in detection mode.
- A channel that has just turned on is stored as 0 until its settle window has run out.
- Every channel is stored as 0 while the power-save wake-up is still in progress.

Top module: `led_fault_capture`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `fault_word` is all zeros and `cap_done` is 0.
- R2: With `det_mode_en` low and `cap_sel` equal to 2'b01, the clock edge that first samples `blank_in` high stores the qualified comparator bits in `fault_word`, with bit i belonging to channel i. The result is visible after that edge.
- R3: With `det_mode_en` low, a rising edge of `blank_in` while `cap_sel` is 2'b00, 2'b10 or 2'b11 changes nothing: `fault_word` keeps its value and `cap_done` stays 0.
- R4: Outside detection mode, a channel whose `out_en` bit is 0 is stored as 0, whatever its comparator says.
- R5: When `det_mode_en` rises, a working time is chosen from `det_time_sel`: 2'b00 gives DET_T0, 2'b01 gives DET_T1, 2'b10 gives DET_T2, 2'b11 gives DET_T3. The capture happens on the edge that comes that many cycles after the edge that first sampled `det_mode_en` high. In this mode, channels with `out_en` clear are stored like any other channel, and `blank_in` edges cause no capture.
- R6: Counting from the first cycle `out_on[i]` is sampled high after being low, channel i is stored as 0 for BLANK_CYC+1 cycles. After that window its comparator bit passes.
- R7: While `waking` is high, a capture stores 0 on every channel. The capture still happens and still strobes `cap_done`.
- R8: `cap_done` is high for exactly one cycle after each update of `fault_word`. Between captures `fault_word` holds its value.
- R9: Detection mode captures once for each rising edge of `det_mode_en`. Staying enabled does not capture again. Dropping the enable before the working time has run out cancels that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_low | input | 16 | Per-channel comparator result, 1 = pin below threshold |
| out_en | input | 16 | Programmed per-channel output enable |
| out_on | input | 16 | Per-channel output currently driving |
| blank_in | input | 1 | Blanking input; its rising edge triggers a normal capture |
| cap_sel | input | 2 | Capture-select field; 2'b01 selects fault capture |
| det_mode_en | input | 1 | Detection-mode enable |
| det_time_sel | input | 2 | Detection-mode working-time select |
| waking | input | 1 | Power-save or wake-up delay in progress |
| fault_word | output | 16 | Held fault status word |
| cap_done | output | 1 | One-cycle strobe after each update |

## Verification
A normal capture is due on the edge that first samples `blank_in` high. The bench raises `blank_in` at a falling edge and reads `fault_word` and `cap_done` at the next falling edge, one register later. A detection-mode capture is due DET_Tn edges after the edge that first sees the enable, so it appears at the (DET_Tn+1)-th falling edge after the enable is driven. The bench checks that `cap_done` is still low one falling edge earlier. For the settle window, the bench raises `blank_in` k cycles after a channel turns on, for k from 0 to BLANK_CYC+1, and expects the channel to be masked up to k = BLANK_CYC.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    CAP_SEL_IDLE  = 2'b00,
    CAP_SEL_FAULT = 2'b01,
    CAP_SEL_RSV2  = 2'b10,
    CAP_SEL_RSV3  = 2'b11
  } cap_sel_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lfc_chan_blank.sv
module lfc_chan_blank #(
  parameter int unsigned BLANK_CYC = 4,
  localparam int unsigned BW = $clog2(BLANK_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic out_on,
  output logic masked
);
  logic          on_q;
  logic [BW-1:0] cnt;
  logic          turn_on;

  assign turn_on = out_on & ~on_q;
  assign masked  = turn_on | (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q <= 1'b0;
      cnt  <= '0;
    end else begin
      on_q <= out_on;
      if (turn_on)
        cnt <= BW'(BLANK_CYC);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lfc_trigger.sv
module lfc_trigger
  import lfc_pkg::*;
#(
  parameter int unsigned DET_T0 = 8,
  parameter int unsigned DET_T1 = 16,
  parameter int unsigned DET_T2 = 32,
  parameter int unsigned DET_T3 = 64,
  localparam int unsigned TMAX = max4(DET_T0, DET_T1, DET_T2, DET_T3),
  localparam int unsigned TW   = $clog2(TMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blank_in,
  input  logic [1:0] cap_sel,
  input  logic       det_mode_en,
  input  logic [1:0] det_time_sel,
  output logic       cap_now
);
  logic          blank_q;
  logic          det_q;
  logic          run;
  logic [TW-1:0] cnt;
  logic [TW-1:0] sel_time;
  logic          norm_fire;
  logic          det_fire;

  always_comb begin
    unique case (det_time_sel)
      2'b00:   sel_time = TW'(DET_T0);
      2'b01:   sel_time = TW'(DET_T1);
      2'b10:   sel_time = TW'(DET_T2);
      default: sel_time = TW'(DET_T3);
    endcase
  end

  assign norm_fire = ~det_mode_en & blank_in & ~blank_q &
                     (cap_sel == 2'(CAP_SEL_FAULT));
  assign det_fire  = det_mode_en & det_q & run & (cnt == '0);
  assign cap_now   = norm_fire | det_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q <= 1'b0;
      det_q   <= 1'b0;
      run     <= 1'b0;
      cnt     <= '0;
    end else begin
      blank_q <= blank_in;
      det_q   <= det_mode_en;
      if (!det_mode_en) begin
        run <= 1'b0;
      end else if (!det_q) begin
        run <= 1'b1;
        cnt <= sel_time - TW'(1);
      end else if (run) begin
        if (cnt == '0) run <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lfc_holder.sv
module lfc_holder #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap_now,
  input  logic [NCH-1:0] qual,
  output logic [NCH-1:0] fault_word,
  output logic           cap_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_word <= '0;
      cap_done   <= 1'b0;
    end else begin
      cap_done <= cap_now;
      if (cap_now) fault_word <= qual;
    end
  end
endmodule

// File: rtl/led_fault_capture.sv
module led_fault_capture #(
  parameter int unsigned NCH       = 16,
  parameter int unsigned BLANK_CYC = 4,
  parameter int unsigned DET_T0    = 8,
  parameter int unsigned DET_T1    = 16,
  parameter int unsigned DET_T2    = 32,
  parameter int unsigned DET_T3    = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cmp_low,
  input  logic [NCH-1:0] out_en,
  input  logic [NCH-1:0] out_on,
  input  logic           blank_in,
  input  logic [1:0]     cap_sel,
  input  logic           det_mode_en,
  input  logic [1:0]     det_time_sel,
  input  logic           waking,
  output logic [NCH-1:0] fault_word,
  output logic           cap_done
);
  logic [NCH-1:0] settle_mask;
  logic [NCH-1:0] qual;
  logic           cap_now;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    lfc_chan_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk    (clk),
      .rst    (rst),
      .out_on (out_on[i]),
      .masked (settle_mask[i])
    );
    assign qual[i] = cmp_low[i] & (out_en[i] | det_mode_en) &
                     ~settle_mask[i] & ~waking;
  end

  lfc_trigger #(
    .DET_T0(DET_T0), .DET_T1(DET_T1), .DET_T2(DET_T2), .DET_T3(DET_T3)
  ) u_trig (
    .clk          (clk),
    .rst          (rst),
    .blank_in     (blank_in),
    .cap_sel      (cap_sel),
    .det_mode_en  (det_mode_en),
    .det_time_sel (det_time_sel),
    .cap_now      (cap_now)
  );

  lfc_holder #(.NCH(NCH)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .cap_now    (cap_now),
    .qual       (qual),
    .fault_word (fault_word),
    .cap_done   (cap_done)
  );
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] cmp_low,
  input logic [NCH-1:0] out_en,
  input logic [1:0]     cap_sel,
  input logic           det_mode_en,
  input logic           waking,
  input logic [NCH-1:0] fault_word,
  input logic           cap_done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fault_word == '0) && !cap_done);

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_word) |-> cap_done);

  // R2
  subset_of_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> (fault_word & ~$past(cmp_low)) == '0);

  // R3
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_done && !$past(det_mode_en)) |-> $past(cap_sel) == 2'b01);

  // R4
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_done && !$past(det_mode_en)) |-> (fault_word & ~$past(out_en)) == '0);

  // R7
  wake_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_done && $past(waking)) |-> fault_word == '0);
endmodule

bind led_fault_capture lfc_checker #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_low     (cmp_low),
  .out_en      (out_en),
  .cap_sel     (cap_sel),
  .det_mode_en (det_mode_en),
  .waking      (waking),
  .fault_word  (fault_word),
  .cap_done    (cap_done)
);

// File: tb/tb_led_fault_capture.sv
module tb_led_fault_capture;
  localparam int CLK_P = 10;
  localparam int BCYC  = 4;
  localparam int T0 = 8, T1 = 16, T2 = 32, T3 = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cmp_low = '0, out_en = '0, out_on = '1;
  logic        blank_in = 1'b0;
  logic [1:0]  cap_sel = 2'b01;
  logic        det_mode_en = 1'b0;
  logic [1:0]  det_time_sel = 2'b00;
  logic        waking = 1'b0;
  logic [15:0] fault_word;
  logic        cap_done;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  led_fault_capture #(.NCH(16), .BLANK_CYC(BCYC),
    .DET_T0(T0), .DET_T1(T1), .DET_T2(T2), .DET_T3(T3)) dut (
    .clk(clk), .rst(rst), .cmp_low(cmp_low), .out_en(out_en), .out_on(out_on),
    .blank_in(blank_in), .cap_sel(cap_sel), .det_mode_en(det_mode_en),
    .det_time_sel(det_time_sel), .waking(waking),
    .fault_word(fault_word), .cap_done(cap_done));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // raise blank at a falling edge, look one falling edge later
  task automatic blank_cap(input string req, input logic [15:0] exp_word, input logic exp_done);
    blank_in = 1'b1;
    @(negedge clk);
    chk(req, fault_word, exp_word);
    chk(req, {15'd0, cap_done}, {15'd0, exp_done});
    blank_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset word", fault_word, 16'h0000);
    chk("R1 reset done", {15'd0, cap_done}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {fault_word[14:0], cap_done}, 16'h0000);
    repeat (BCYC + 3) @(negedge clk);
  endtask

  task automatic t_normal;
    out_en = '1; cmp_low = 16'hA5C3; cap_sel = 2'b01;
    blank_cap("R2 capture", 16'hA5C3, 1'b1);
    chk("R8 strobe one cycle", {15'd0, cap_done}, 16'h0000);
    chk("R8 hold", fault_word, 16'hA5C3);
    cmp_low = 16'h5A3C;
    blank_cap("R2 second pattern", 16'h5A3C, 1'b1);
  endtask

  task automatic t_mask;
    out_en = 16'h00FF; cmp_low = 16'hFFFF;
    blank_cap("R4 low half enabled", 16'h00FF, 1'b1);
    out_en = 16'hF0F0; cmp_low = 16'h3C3C;
    blank_cap("R4 alternating", 16'h3030, 1'b1);
  endtask

  task automatic t_sel;
    out_en = '1; cmp_low = 16'h1111;
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      cap_sel = 2'(s);
      blank_cap("R3 select ignored", 16'h3030, 1'b0);
    end
    cap_sel = 2'b01;
  endtask

  task automatic t_settle;
    out_en = '1; cmp_low = '1;
    for (int k = 0; k <= BCYC + 1; k++) begin
      out_on[3] = 1'b0;
      repeat (2) @(negedge clk);
      out_on[3] = 1'b1;
      repeat (k) @(negedge clk);
      blank_cap("R6 settle window", (k > BCYC) ? 16'hFFFF : 16'hFFF7, 1'b1);
    end
  endtask

  task automatic t_wake;
    cmp_low = 16'hBEEF; out_en = '1; waking = 1'b1;
    blank_cap("R7 waking zeros", 16'h0000, 1'b1);
    waking = 1'b0;
    blank_cap("R7 after wake", 16'hBEEF, 1'b1);
  endtask

  task automatic t_det(input logic [1:0] sel, input int tlen, input logic [15:0] pat);
    out_en = 16'h0000; cmp_low = pat; det_time_sel = sel;
    det_mode_en = 1'b1;
    for (int j = 1; j <= tlen; j++) begin
      @(negedge clk);
      if (j == 2) blank_in = 1'b1;
      if (j == 3) blank_in = 1'b0;
      if (j == tlen) chk("R5 not yet", {15'd0, cap_done}, 16'h0000);
    end
    @(negedge clk);
    chk("R5 det capture word", fault_word, pat);
    chk("R5 det capture done", {15'd0, cap_done}, 16'h0001);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (cap_done) chk("R9 no repeat", 16'h0001, 16'h0000);
    end
    chk("R9 held", fault_word, pat);
    det_mode_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_cancel;
    cmp_low = 16'h0F0F; det_time_sel = 2'b00; det_mode_en = 1'b1;
    repeat (3) @(negedge clk);
    det_mode_en = 1'b0;
    for (int j = 0; j < T0 + 4; j++) begin
      @(negedge clk);
      if (cap_done) chk("R9 cancelled", 16'h0001, 16'h0000);
    end
    chk("R9 cancel keeps word", fault_word, 16'h7777);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_mask();
    t_sel();
    t_settle();
    t_wake();
    t_det(2'b00, T0, 16'h1234);
    t_det(2'b01, T1, 16'hC001);
    t_det(2'b11, T3, 16'h7777);
    t_cancel();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule